// File: doc/BRIEF.md
# Variable-Region Erase Range Walker

This sequencer turns one erase request into a run of single-block erase commands. The request gives a byte offset and a length. The flash array is described by a small table of regions. Each region has a start offset, a block size given as a power of two, and a block count. The walker first locates the region that holds the first byte of the request and the region in force at the end address. It rejects the request if either address is off the block grid of its region. If both are aligned, it issues one command per block. Each command carries a chip index, an in-chip address and a block size. The walker moves to the next region when a region's last block is done, and to the next chip when the in-chip address passes the chip size.

Requests enter on a valid/ready port. The walker accepts a request only while it is idle, and it holds `req_ready` low until the status of that request has been shown. Block commands leave on a second valid/ready port. While `cmd_valid` is high and `cmd_ready` is low, the command fields stay stable. After a command is accepted, the walker waits for a one-cycle `done_pulse` from the erase engine before it issues the next command. A `done_err` bit sampled with that pulse aborts the walk. The result appears for one cycle on `stat_valid` with a two-bit code.

Top module: `erase_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and both `cmd_valid` and `stat_valid` are 0.
- R2: The start region is the last entry, scanning from entry 0 within `rgn_num`, whose start is at or below the offset. If the offset is not a multiple of that region's block size, the walker reports status 1 (invalid) and issues no command.
- R3: The end address is offset plus length. Its region is found with the same at-or-above-start scan, so an end address equal to a region's start uses that region's block size. If the end address is off that grid, the walker reports status 1 and issues no command.
- R4: The first command's chip index is offset >> `chip_shift`. Its in-chip address is the offset with the chip bits cleared. Every command's in-chip address is below 2^`chip_shift`.
- R5: Each command's size is 2^log2 of the current region, and it is a single set bit. The next command starts exactly one size later.
- R6: When the running offset reaches region start + count × size, the following commands use the next region's size.
- R7: When the in-chip address reaches 2^`chip_shift`, it wraps to 0 and the chip index increments. If the chip index then equals `num_chips`, the walk ends with status 0 (ok).
- R8: A `done_err` of 1 with `done_pulse` ends the walk at once with status 2 (device error). No further command is issued.
- R9: The command fields are held stable while `cmd_valid` is high and `cmd_ready` is low. No new command is offered between an accepted command and its `done_pulse`. A `done_pulse` while no command is outstanding is ignored.
- R10: `stat_valid` is a one-cycle pulse. `req_ready` and `cmd_valid` are never high together.
- R11: Once the remaining length is used up, the walk ends with status 0. A zero-length request that passes both alignment checks yields status 0 and no command.
- R12: An offset below the first region's start, or a start chip index at or above `num_chips`, yields status 1 and no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Erase request offered |
| req_ready | output | 1 | Walker idle, request accepted on this cycle if valid |
| req_offset | input | 32 | Byte offset of the request |
| req_length | input | 32 | Byte length of the request |
| rgn_start | input | 128 | Region start offsets, entry k in bits [32k+31:32k] |
| rgn_log2 | input | 20 | Region block size log2, entry k in bits [5k+4:5k] |
| rgn_count | input | 64 | Region block counts, entry k in bits [16k+15:16k] |
| rgn_num | input | 3 | Number of valid regions (1 to 4) |
| chip_shift | input | 5 | log2 of the chip size in bytes |
| num_chips | input | 9 | Number of chips |
| cmd_valid | output | 1 | Block command offered |
| cmd_ready | input | 1 | Erase engine takes the command |
| cmd_chip | output | 8 | Chip index of the block |
| cmd_addr | output | 32 | In-chip byte address of the block |
| cmd_size | output | 32 | Block size in bytes |
| done_pulse | input | 1 | One-cycle completion of the outstanding block |
| done_err | input | 1 | Completion carries an error |
| stat_valid | output | 1 | One-cycle final status strobe |
| stat_code | output | 2 | 0 ok, 1 invalid request, 2 device error |

## Verification
Region advance and chip wrap can be resolved in the same completion step. This happens when a region ends exactly on a chip boundary. The bench builds that case with a 4 KiB chip whose second region ends at 0x1000, and walks a request across it with `cmd_ready` stalling. It judges the pair by the command that follows the boundary. That command must name the next chip at in-chip address 0 and carry the next region's block size. If either update is dropped or applied one step late, the chip, the address or the size of that command is wrong.

// File: rtl/walker_pkg.sv
package walker_pkg;
  typedef enum logic [1:0] {
    STAT_OK     = 2'd0,
    STAT_INVAL  = 2'd1,
    STAT_DEVERR = 2'd2
  } stat_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_CHECK,
    W_ISSUE,
    W_WAIT,
    W_STAT
  } wstate_e;
endpackage

// File: rtl/region_lookup.sv
module region_lookup #(
  parameter int NREG = 4,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NREG),
  localparam int NW  = $clog2(NREG + 1)
) (
  input  logic [NREG*AW-1:0] starts,
  input  logic [NW-1:0]      num,
  input  logic [AW-1:0]      probe,
  output logic [IW-1:0]      idx,
  output logic               hit
);
  logic [NW-1:0] cnt;
  logic          stop;

  // Count leading entries whose start is at or below the probe address.
  always_comb begin
    cnt  = '0;
    stop = 1'b0;
    for (int k = 0; k < NREG; k++) begin
      if (!stop && (NW'(k) < num) && (probe >= starts[k*AW +: AW]))
        cnt = NW'(k + 1);
      else
        stop = 1'b1;
    end
    hit = (cnt != '0);
    idx = IW'(cnt - NW'(1));
  end
endmodule

// File: rtl/addr_split.sv
module addr_split #(
  parameter int AW  = 32,
  parameter int CHW = 8,
  parameter int SW  = 5
) (
  input  logic [AW-1:0]  ofs,
  input  logic [SW-1:0]  shift,
  output logic [CHW:0]   chip,
  output logic [AW-1:0]  inchip
);
  logic [AW-1:0] upper;

  always_comb begin
    upper  = ofs >> shift;
    chip   = (upper > AW'({1'b0, {CHW{1'b1}}})) ? {1'b1, {CHW{1'b1}}} : upper[CHW:0];
    inchip = ofs & ~({AW{1'b1}} << shift);
  end
endmodule

// File: rtl/erase_walker.sv
module erase_walker
  import walker_pkg::*;
#(
  parameter int NREG = 4,
  parameter int AW   = 32,
  parameter int LW   = 5,
  parameter int CW   = 16,
  parameter int CHW  = 8,
  parameter int SW   = 5,
  localparam int IW  = $clog2(NREG),
  localparam int NW  = $clog2(NREG + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [AW-1:0]      req_offset,
  input  logic [AW-1:0]      req_length,
  input  logic [NREG*AW-1:0] rgn_start,
  input  logic [NREG*LW-1:0] rgn_log2,
  input  logic [NREG*CW-1:0] rgn_count,
  input  logic [NW-1:0]      rgn_num,
  input  logic [SW-1:0]      chip_shift,
  input  logic [CHW:0]       num_chips,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [CHW-1:0]     cmd_chip,
  output logic [AW-1:0]      cmd_addr,
  output logic [AW-1:0]      cmd_size,
  input  logic               done_pulse,
  input  logic               done_err,
  output logic               stat_valid,
  output logic [1:0]         stat_code
);
  wstate_e       state;
  logic [AW-1:0] ofs_q, len_q, addr_q;
  logic [CHW-1:0] chip_q;
  logic [IW-1:0] ridx_q;
  stat_e         stat_q;

  // Per-region views of the flattened table.
  logic [AW-1:0] r_start [NREG];
  logic [AW-1:0] r_size  [NREG];
  logic [AW-1:0] r_end   [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_rgn
    assign r_start[g] = rgn_start[g*AW +: AW];
    assign r_size[g]  = AW'(1) << rgn_log2[g*LW +: LW];
    assign r_end[g]   = r_start[g] + (AW'(rgn_count[g*CW +: CW]) << rgn_log2[g*LW +: LW]);
  end

  // Region lookups for the first byte and for the end address.
  logic [IW-1:0] s_idx, e_idx;
  logic          s_hit, e_hit;
  logic [AW-1:0] end_ofs;

  assign end_ofs = ofs_q + len_q;

  region_lookup #(.NREG(NREG), .AW(AW)) u_start_lu (
    .starts(rgn_start), .num(rgn_num), .probe(ofs_q), .idx(s_idx), .hit(s_hit)
  );

  region_lookup #(.NREG(NREG), .AW(AW)) u_end_lu (
    .starts(rgn_start), .num(rgn_num), .probe(end_ofs), .idx(e_idx), .hit(e_hit)
  );

  logic [CHW:0]  sp_chip;
  logic [AW-1:0] sp_addr;

  addr_split #(.AW(AW), .CHW(CHW), .SW(SW)) u_split (
    .ofs(ofs_q), .shift(chip_shift), .chip(sp_chip), .inchip(sp_addr)
  );

  logic s_mis, e_mis, reject;

  always_comb begin
    s_mis  = (ofs_q & (r_size[s_idx] - AW'(1))) != '0;
    e_mis  = (end_ofs & (r_size[e_idx] - AW'(1))) != '0;
    reject = !s_hit || !e_hit || s_mis || e_mis || (sp_chip >= num_chips);
  end

  // Step arithmetic applied on a clean completion.
  logic [AW-1:0] blk, ofs_nx, addr_nx;
  logic [CHW:0]  chip_nx;
  logic          last_len, rgn_adv, more_rgn, wrap, out_of_chips;

  always_comb begin
    blk          = r_size[ridx_q];
    ofs_nx       = ofs_q + blk;
    addr_nx      = addr_q + blk;
    chip_nx      = {1'b0, chip_q} + (CHW+1)'(1);
    last_len     = (len_q <= blk);
    rgn_adv      = (ofs_nx == r_end[ridx_q]);
    more_rgn     = (NW'(ridx_q) + NW'(1)) < rgn_num;
    wrap         = (addr_nx >> chip_shift) != '0;
    out_of_chips = wrap && (chip_nx >= num_chips);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= W_IDLE;
      ofs_q  <= '0;
      len_q  <= '0;
      addr_q <= '0;
      chip_q <= '0;
      ridx_q <= '0;
      stat_q <= STAT_OK;
    end else begin
      case (state)
        W_IDLE: begin
          if (req_valid) begin
            ofs_q <= req_offset;
            len_q <= req_length;
            state <= W_CHECK;
          end
        end
        W_CHECK: begin
          ridx_q <= s_idx;
          chip_q <= sp_chip[CHW-1:0];
          addr_q <= sp_addr;
          if (reject) begin
            stat_q <= STAT_INVAL;
            state  <= W_STAT;
          end else if (len_q == '0) begin
            stat_q <= STAT_OK;
            state  <= W_STAT;
          end else begin
            state <= W_ISSUE;
          end
        end
        W_ISSUE: begin
          if (cmd_ready) state <= W_WAIT;
        end
        W_WAIT: begin
          if (done_pulse) begin
            if (done_err) begin
              stat_q <= STAT_DEVERR;
              state  <= W_STAT;
            end else begin
              ofs_q  <= ofs_nx;
              len_q  <= last_len ? '0 : len_q - blk;
              addr_q <= wrap ? '0 : addr_nx;
              if (wrap) chip_q <= chip_nx[CHW-1:0];
              if (rgn_adv && more_rgn) ridx_q <= ridx_q + IW'(1);
              if (last_len || out_of_chips) begin
                stat_q <= STAT_OK;
                state  <= W_STAT;
              end else begin
                state <= W_ISSUE;
              end
            end
          end
        end
        W_STAT:  state <= W_IDLE;
        default: state <= W_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == W_IDLE);
  assign cmd_valid  = (state == W_ISSUE);
  assign cmd_chip   = chip_q;
  assign cmd_addr   = addr_q;
  assign cmd_size   = blk;
  assign stat_valid = (state == W_STAT);
  assign stat_code  = stat_q;
endmodule

// File: rtl/erase_walker_chk.sv
module erase_walker_chk #(
  parameter int AW  = 32,
  parameter int CHW = 8,
  parameter int SW  = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_ready,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic [CHW-1:0] cmd_chip,
  input logic [AW-1:0]  cmd_addr,
  input logic [AW-1:0]  cmd_size,
  input logic           done_pulse,
  input logic           stat_valid,
  input logic [SW-1:0]  chip_shift,
  input logic [CHW:0]   num_chips
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= 1'b0;
    else if (cmd_valid && cmd_ready) outstanding <= 1'b1;
    else if (done_pulse) outstanding <= 1'b0;
  end

  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_chip) && $stable(cmd_addr) && $stable(cmd_size));

  assert_wait_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !cmd_valid);

  assert_stat_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);

  assert_port_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && cmd_valid));

  assert_pow2_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $countones(cmd_size) == 1);

  assert_inchip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_addr >> chip_shift) == '0);

  assert_chip_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> {1'b0, cmd_chip} < num_chips);
endmodule

bind erase_walker erase_walker_chk #(.AW(AW), .CHW(CHW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_chip(cmd_chip), .cmd_addr(cmd_addr),
  .cmd_size(cmd_size), .done_pulse(done_pulse), .stat_valid(stat_valid),
  .chip_shift(chip_shift), .num_chips(num_chips)
);

// File: tb/erase_walker_test.sv
module erase_walker_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_offset = '0, req_length = '0;
  logic [127:0] rgn_start;
  logic [19:0]  rgn_log2;
  logic [63:0]  rgn_count;
  logic [2:0]   rgn_num = 3'd3;
  logic [4:0]   chip_shift = 5'd12;
  logic [8:0]   num_chips = 9'd4;
  logic         cmd_valid;
  logic         cmd_ready = 1'b1;
  logic [7:0]   cmd_chip;
  logic [31:0]  cmd_addr, cmd_size;
  logic         done_pulse = 1'b0, done_err = 1'b0;
  logic         stat_valid;
  logic [1:0]   stat_code;

  erase_walker uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int ncmd = 0, nstat = 0, pend = 0, err_at = -1, cyc = 0;
  logic stall = 1'b0, pend_err = 1'b0, force_done = 1'b0;
  logic [1:0]  last_code;
  logic [7:0]  got_chip [16];
  logic [31:0] got_addr [16];
  logic [31:0] got_size [16];

  // Erase engine model and monitor, all on the falling edge.
  always @(negedge clk) begin
    done_pulse = 1'b0;
    done_err   = 1'b0;
    if (force_done) done_pulse = 1'b1;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        done_pulse = 1'b1;
        done_err   = pend_err;
      end
    end
    cmd_ready = stall ? (cyc % 3 == 0) : 1'b1;
    cyc = cyc + 1;
    if (cmd_valid && cmd_ready) begin
      if (ncmd < 16) begin
        got_chip[ncmd] = cmd_chip;
        got_addr[ncmd] = cmd_addr;
        got_size[ncmd] = cmd_size;
      end
      pend_err = (ncmd == err_at);
      ncmd = ncmd + 1;
      pend = 2;
    end
    if (stat_valid) begin
      nstat = nstat + 1;
      last_code = stat_code;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Region table: r0 @0 512B x4, r1 @0x800 1KiB x2, r2 @0x1000 2KiB x6.
  task automatic set_table();
    rgn_start = {32'h0, 32'h1000, 32'h800, 32'h0};
    rgn_log2  = {5'd0, 5'd11, 5'd10, 5'd9};
    rgn_count = {16'd0, 16'd6, 16'd2, 16'd4};
    rgn_num   = 3'd3;
  endtask

  task automatic walk(input logic [31:0] ofs, input logic [31:0] len,
                      input logic stl, input int err_idx);
    int s0;
    stall  = stl;
    err_at = err_idx;
    ncmd   = 0;
    s0     = nstat;
    @(negedge clk);
    req_offset = ofs;
    req_length = len;
    req_valid  = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (nstat == s0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_cmd(input string tag, input int i, input logic [7:0] ch,
                         input logic [31:0] ad, input logic [31:0] sz);
    check({tag, " chip"}, 32'(got_chip[i]), 32'(ch));
    check({tag, " addr"}, got_addr[i], ad);
    check({tag, " size"}, got_size[i], sz);
  endtask

  task automatic t_reset();
    check("R1 req_ready", 32'(req_ready), 32'd1);
    check("R1 cmd_valid", 32'(cmd_valid), 32'd0);
    check("R1 stat_valid", 32'(stat_valid), 32'd0);
  endtask

  task automatic t_region_step();
    walk(32'h400, 32'hC00, 1'b0, -1);
    check("R11 status ok", 32'(last_code), 32'd0);
    check("R5 count", 32'(ncmd), 32'd4);
    chk_cmd("R4 first", 0, 8'd0, 32'h400, 32'd512);
    chk_cmd("R5 second", 1, 8'd0, 32'h600, 32'd512);
    chk_cmd("R6 region advance", 2, 8'd0, 32'h800, 32'd1024);
    chk_cmd("R6 region1 tail", 3, 8'd0, 32'hC00, 32'd1024);
  endtask

  task automatic t_chip_cross();
    walk(32'hC00, 32'h1400, 1'b1, -1);
    check("R7 status ok", 32'(last_code), 32'd0);
    check("R7 count", 32'(ncmd), 32'd3);
    chk_cmd("R9 stalled first", 0, 8'd0, 32'hC00, 32'd1024);
    chk_cmd("R7 wrap plus R6 advance", 1, 8'd1, 32'h0, 32'd2048);
    chk_cmd("R7 after wrap", 2, 8'd1, 32'h800, 32'd2048);
  endtask

  task automatic t_bad_start();
    walk(32'h900, 32'h400, 1'b0, -1);
    check("R2 invalid", 32'(last_code), 32'd1);
    check("R2 no cmd", 32'(ncmd), 32'd0);
  endtask

  task automatic t_bad_end();
    walk(32'h400, 32'h1000, 1'b0, -1);
    check("R3 invalid end", 32'(last_code), 32'd1);
    check("R3 no cmd", 32'(ncmd), 32'd0);
    walk(32'h800, 32'h800, 1'b0, -1);
    check("R3 boundary end ok", 32'(last_code), 32'd0);
    check("R3 boundary count", 32'(ncmd), 32'd2);
  endtask

  task automatic t_dev_error();
    walk(32'h1000, 32'h3000, 1'b0, 1);
    check("R8 deverr", 32'(last_code), 32'd2);
    check("R8 stopped", 32'(ncmd), 32'd2);
  endtask

  task automatic t_chip_limit();
    num_chips = 9'd2;
    walk(32'h1000, 32'h3000, 1'b0, -1);
    check("R7 chip limit ok", 32'(last_code), 32'd0);
    check("R7 chip limit count", 32'(ncmd), 32'd2);
    walk(32'h2000, 32'h800, 1'b0, -1);
    check("R12 chip out of range", 32'(last_code), 32'd1);
    check("R12 no cmd", 32'(ncmd), 32'd0);
    num_chips = 9'd4;
  endtask

  task automatic t_zero_len();
    walk(32'h400, 32'h0, 1'b0, -1);
    check("R11 zero length ok", 32'(last_code), 32'd0);
    check("R11 zero length no cmd", 32'(ncmd), 32'd0);
  endtask

  task automatic t_below_first();
    rgn_start[31:0] = 32'h200;
    walk(32'h100, 32'h100, 1'b0, -1);
    check("R12 below first", 32'(last_code), 32'd1);
    check("R12 below first no cmd", 32'(ncmd), 32'd0);
    set_table();
  endtask

  task automatic t_stray_done();
    int s0;
    s0 = nstat;
    @(negedge clk);
    force_done = 1'b1;
    @(negedge clk);
    force_done = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 stray done no status", 32'(nstat), 32'(s0));
    check("R9 stray done idle", 32'(req_ready), 32'd1);
    check("R10 no cmd after stray", 32'(cmd_valid), 32'd0);
  endtask

  initial begin
    set_table();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_region_step();
    t_chip_cross();
    t_bad_start();
    t_bad_end();
    t_dev_error();
    t_chip_limit();
    t_zero_len();
    t_below_first();
    t_stray_done();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule